// File: doc/BRIEF.md
# Coherent Set-Associative Address Translation Cache

This block caches recent virtual-page to physical-page mappings so that most memory accesses are translated without touching the page tables. A requester presents a virtual address and an access kind. In the same cycle the block reports exactly one of three outcomes. A hit returns a physical address. A miss asks an external page-table walker to fetch the mapping. A fault means the stored permissions forbid the access. Pages are 4 KiB. The low 12 address bits pass straight through, and the virtual page number supplies both the set index and the tag.

After a miss, the walker installs the mapping through a refill port and the requester retries. The walker also uses the refill port to install a mapping with the dirty bit set after a write to a clean page. Coherency with the page tables is kept in hardware. A write to the page-table base register empties the whole structure, and a change to one page-table entry removes only the matching mapping. Within a set, the way to replace is chosen by least-recently-used order.

Top module: `tlb_coherent`

## Requirements
- R1: After reset no mapping is held, so every lookup reports a miss.
- R2: A lookup hits when its set holds a valid entry with an equal tag, the entry allows the access, and the access is not a write to a clean page. On a hit, `lk_paddr` is the stored page number followed by `lk_vaddr[11:0]`, in the same cycle.
- R3: While `lk_req` is high exactly one of `lk_hit`, `lk_miss`, `lk_fault` is high. While `lk_req` is low all three are low and `lk_paddr` is zero.
- R4: A lookup with no matching valid entry reports a miss. A refill becomes visible from the next cycle, so a retried lookup of that page then hits.
- R5: Access kind encoding on `lk_kind`: 2'b00 read (needs the read bit), 2'b01 write (needs the write bit), 2'b10 execute (needs the execute bit), and 2'b11 is treated as read. A matching entry whose bit is clear gives `lk_fault` and no hit.
- R6: A permitted write to an entry whose dirty bit is clear reports a miss. A refill of a page already held overwrites that same way, so no page is ever held twice.
- R7: `tbl_base_wr` invalidates every entry at the clock edge. A refill in the same cycle is discarded.
- R8: `entry_inv` removes only the entry whose page number equals `entry_inv_vpn`. Every other entry is left as it was. A refill of that same page in the same cycle is discarded.
- R9: The set index is the low log2(sets) bits of the page number and the tag is the rest. A refill of a new page takes the lowest-numbered invalid way of its set, if any.
- R10: When a refill finds its set full, it replaces the least recently used way. Hits and committed refills both count as use. If a refill commits in a cycle, only the refill updates the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | VADDR_W | Virtual address to translate |
| lk_kind | input | 2 | Access kind (read, write, execute) |
| lk_hit | output | 1 | Translation valid |
| lk_miss | output | 1 | Walker must fetch or mark dirty |
| lk_fault | output | 1 | Permission violation |
| lk_paddr | output | PADDR_W | Physical address on hit |
| rf_req | input | 1 | Install a mapping |
| rf_vpn | input | VADDR_W-12 | Page number of the mapping |
| rf_ppn | input | PADDR_W-12 | Physical page number |
| rf_rd | input | 1 | Read permitted |
| rf_wr | input | 1 | Write permitted |
| rf_ex | input | 1 | Execute permitted |
| rf_dirty | input | 1 | Page already dirty |
| tbl_base_wr | input | 1 | Base register written: flush all |
| entry_inv | input | 1 | Drop one mapping |
| entry_inv_vpn | input | VADDR_W-12 | Page number to drop |

## Verification
The bench builds the block with 16 entries in 4 ways, which gives only four sets. Page numbers are drawn from a pool of twenty, so sets fill, evict and refill many times. Collisions between refill, invalidate, flush and lookup in the same cycle then occur often enough to test every precedence rule. The same build also keeps full-set replacement order and the same-page overwrite case within a few cycles of directed stimulus.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned PG_OFF_W = 12;

  localparam logic [1:0] ACC_READ  = 2'b00;
  localparam logic [1:0] ACC_WRITE = 2'b01;
  localparam logic [1:0] ACC_EXEC  = 2'b10;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
    logic dirty;
  } tlb_perm_t;

  // access permitted by the stored rights (kind 2'b11 behaves as read)
  function automatic logic perm_allows(tlb_perm_t p, logic [1:0] kind);
    case (kind)
      ACC_WRITE: return p.wr;
      ACC_EXEC:  return p.ex;
      default:   return p.rd;
    endcase
  endfunction

  // permitted write to a clean page: walker must mark it dirty first
  function automatic logic needs_dirty_mark(tlb_perm_t p, logic [1:0] kind);
    return (kind == ACC_WRITE) && p.wr && !p.dirty;
  endfunction
endpackage

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int SET_W = 4,
  parameter int WAY_W = 2,
  parameter int TAG_W = 16,
  parameter int PPN_W = 20
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  flush_all,
  input  logic                                  inv_en,
  input  logic [SET_W-1:0]                      inv_set,
  input  logic [TAG_W-1:0]                      inv_tag,
  input  logic                                  wr_en,
  input  logic [SET_W-1:0]                      wr_set,
  input  logic [WAY_W-1:0]                      wr_way,
  input  logic [TAG_W-1:0]                      wr_tag,
  input  logic [PPN_W-1:0]                      wr_ppn,
  input  tlb_perm_t                             wr_perm,
  output logic [SETS-1:0][WAYS-1:0]             valid_q,
  output logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q,
  output logic [SETS-1:0][WAYS-1:0][PPN_W-1:0]  ppn_q,
  output tlb_perm_t [SETS-1:0][WAYS-1:0]        perm_q
);
  // valid bits: clear, then install; flush overrides everything
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (flush_all) begin
      valid_q <= '0;
    end else begin
      for (int w = 0; w < WAYS; w++) begin
        if (inv_en && valid_q[inv_set][w] && (tag_q[inv_set][w] == inv_tag))
          valid_q[inv_set][w] <= 1'b0;
      end
      if (wr_en)
        valid_q[wr_set][wr_way] <= 1'b1;
    end
  end

  // payload needs no reset: it is never used while its valid bit is low
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set][wr_way]  <= wr_tag;
      ppn_q[wr_set][wr_way]  <= wr_ppn;
      perm_q[wr_set][wr_way] <= wr_perm;
    end
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int SET_W = 4,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [SET_W-1:0] vic_set,
  output logic [WAY_W-1:0] vic_way
);
  // per-way age rank: 0 = most recent, WAYS-1 = least recent
  logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_q[touch_set][w] <= '0;
        else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
          age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
      end
    end
  end

  always_comb begin
    vic_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (age_q[vic_set][w] == WAY_W'(WAYS - 1))
        vic_way = WAY_W'(w);
  end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2,
  parameter int TAG_W = 16,
  parameter int PPN_W = 20
) (
  input  logic                       req,
  input  logic [1:0]                 kind,
  input  logic [TAG_W-1:0]           tag,
  input  logic [WAYS-1:0]            way_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [WAYS-1:0][PPN_W-1:0] way_ppn,
  input  tlb_perm_t [WAYS-1:0]       way_perm,
  output logic [WAYS-1:0]            match_vec,
  output logic [WAY_W-1:0]           match_way,
  output logic [PPN_W-1:0]           ppn_sel,
  output logic                       hit,
  output logic                       miss,
  output logic                       fault
);
  tlb_perm_t perm_sel;
  logic      any_match;

  always_comb begin
    match_vec = '0;
    match_way = '0;
    ppn_sel   = '0;
    perm_sel  = '0;
    for (int w = 0; w < WAYS; w++) begin
      match_vec[w] = way_valid[w] && (way_tag[w] == tag);
      if (match_vec[w]) begin
        match_way = WAY_W'(w);
        ppn_sel   = way_ppn[w];
        perm_sel  = way_perm[w];
      end
    end
    any_match = |match_vec;
    hit   = req && any_match && perm_allows(perm_sel, kind)
                 && !needs_dirty_mark(perm_sel, kind);
    fault = req && any_match && !perm_allows(perm_sel, kind);
    miss  = req && (!any_match || needs_dirty_mark(perm_sel, kind));
  end
endmodule

// File: rtl/tlb_refill_pick.sv
module tlb_refill_pick #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2,
  parameter int TAG_W = 16
) (
  input  logic [WAYS-1:0]            way_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [TAG_W-1:0]           tag,
  input  logic [WAY_W-1:0]           lru_victim,
  output logic [WAY_W-1:0]           pick_way
);
  // priority: same page > lowest invalid way > least recently used
  always_comb begin
    pick_way = lru_victim;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!way_valid[w])
        pick_way = WAY_W'(w);
    for (int w = 0; w < WAYS; w++)
      if (way_valid[w] && (way_tag[w] == tag))
        pick_way = WAY_W'(w);
  end
endmodule

// File: rtl/tlb_coherent.sv
module tlb_coherent
  import tlb_pkg::*;
#(
  parameter int VADDR_W = 32,
  parameter int PADDR_W = 32,
  parameter int ENTRIES = 64,
  parameter int WAYS    = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  lk_req,
  input  logic [VADDR_W-1:0]                    lk_vaddr,
  input  logic [1:0]                            lk_kind,
  output logic                                  lk_hit,
  output logic                                  lk_miss,
  output logic                                  lk_fault,
  output logic [PADDR_W-1:0]                    lk_paddr,
  input  logic                                  rf_req,
  input  logic [VADDR_W-tlb_pkg::PG_OFF_W-1:0]  rf_vpn,
  input  logic [PADDR_W-tlb_pkg::PG_OFF_W-1:0]  rf_ppn,
  input  logic                                  rf_rd,
  input  logic                                  rf_wr,
  input  logic                                  rf_ex,
  input  logic                                  rf_dirty,
  input  logic                                  tbl_base_wr,
  input  logic                                  entry_inv,
  input  logic [VADDR_W-tlb_pkg::PG_OFF_W-1:0]  entry_inv_vpn
);
  localparam int OFF_W = PG_OFF_W;
  localparam int VPN_W = VADDR_W - OFF_W;
  localparam int PPN_W = PADDR_W - OFF_W;
  localparam int SETS  = ENTRIES / WAYS;
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = VPN_W - SET_W;

  function automatic logic [SET_W-1:0] set_of(input logic [VPN_W-1:0] vpn);
    return vpn[SET_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [VPN_W-1:0] vpn);
    return vpn[VPN_W-1:SET_W];
  endfunction

  function automatic logic [PADDR_W-1:0] join_paddr(input logic [PPN_W-1:0] ppn,
                                                    input logic [OFF_W-1:0] off);
    return {ppn, off};
  endfunction

  // storage
  logic [SETS-1:0][WAYS-1:0]            valid_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
  logic [SETS-1:0][WAYS-1:0][PPN_W-1:0] ppn_q;
  tlb_perm_t [SETS-1:0][WAYS-1:0]       perm_q;

  // named events for the checker
  logic [VPN_W-1:0] lk_vpn;
  logic [SET_W-1:0] lk_set;
  logic [SET_W-1:0] rf_set;
  logic [TAG_W-1:0] rf_tag;
  logic [SET_W-1:0] inv_set;
  logic [TAG_W-1:0] inv_tag;
  logic [WAYS-1:0]  match_vec;
  logic [WAY_W-1:0] match_way;
  logic [PPN_W-1:0] hit_ppn;
  logic [WAY_W-1:0] lru_victim;
  logic [WAY_W-1:0] rf_way;
  logic             rf_commit;
  logic             inv_same_page;
  logic             touch_en;
  logic [SET_W-1:0] touch_set;
  logic [WAY_W-1:0] touch_way;
  tlb_perm_t        rf_perm;

  assign lk_vpn        = lk_vaddr[VADDR_W-1:OFF_W];
  assign lk_set        = set_of(lk_vpn);
  assign rf_set        = set_of(rf_vpn);
  assign rf_tag        = tag_of(rf_vpn);
  assign inv_set       = set_of(entry_inv_vpn);
  assign inv_tag       = tag_of(entry_inv_vpn);
  assign rf_perm       = '{rd: rf_rd, wr: rf_wr, ex: rf_ex, dirty: rf_dirty};

  // flush and same-page invalidate both veto a refill
  assign inv_same_page = entry_inv && (entry_inv_vpn == rf_vpn);
  assign rf_commit     = rf_req && !tbl_base_wr && !inv_same_page;

  // one order update per cycle, refill first
  assign touch_en  = rf_commit || lk_hit;
  assign touch_set = rf_commit ? rf_set : lk_set;
  assign touch_way = rf_commit ? rf_way : match_way;

  tlb_store #(
    .SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W),
    .TAG_W(TAG_W), .PPN_W(PPN_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush_all (tbl_base_wr),
    .inv_en    (entry_inv),
    .inv_set   (inv_set),
    .inv_tag   (inv_tag),
    .wr_en     (rf_commit),
    .wr_set    (rf_set),
    .wr_way    (rf_way),
    .wr_tag    (rf_tag),
    .wr_ppn    (rf_ppn),
    .wr_perm   (rf_perm),
    .valid_q   (valid_q),
    .tag_q     (tag_q),
    .ppn_q     (ppn_q),
    .perm_q    (perm_q)
  );

  tlb_match #(
    .WAYS(WAYS), .WAY_W(WAY_W), .TAG_W(TAG_W), .PPN_W(PPN_W)
  ) u_match (
    .req       (lk_req),
    .kind      (lk_kind),
    .tag       (tag_of(lk_vpn)),
    .way_valid (valid_q[lk_set]),
    .way_tag   (tag_q[lk_set]),
    .way_ppn   (ppn_q[lk_set]),
    .way_perm  (perm_q[lk_set]),
    .match_vec (match_vec),
    .match_way (match_way),
    .ppn_sel   (hit_ppn),
    .hit       (lk_hit),
    .miss      (lk_miss),
    .fault     (lk_fault)
  );

  tlb_lru #(
    .SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)
  ) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (touch_en),
    .touch_set (touch_set),
    .touch_way (touch_way),
    .vic_set   (rf_set),
    .vic_way   (lru_victim)
  );

  tlb_refill_pick #(
    .WAYS(WAYS), .WAY_W(WAY_W), .TAG_W(TAG_W)
  ) u_pick (
    .way_valid  (valid_q[rf_set]),
    .way_tag    (tag_q[rf_set]),
    .tag        (rf_tag),
    .lru_victim (lru_victim),
    .pick_way   (rf_way)
  );

  assign lk_paddr = lk_hit ? join_paddr(hit_ppn, lk_vaddr[OFF_W-1:0]) : '0;
endmodule

// File: rtl/tlb_coherent_chk.sv
module tlb_coherent_chk #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int SET_W = 4,
  parameter int WAY_W = 2,
  parameter int TAG_W = 16
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 lk_req,
  input logic                                 lk_hit,
  input logic                                 lk_miss,
  input logic                                 lk_fault,
  input logic [11:0]                          lk_off,
  input logic [11:0]                          pa_off,
  input logic                                 flush,
  input logic                                 inv_en,
  input logic [SET_W-1:0]                     inv_set,
  input logic [TAG_W-1:0]                     inv_tag,
  input logic                                 rf_commit,
  input logic [SET_W-1:0]                     rf_set,
  input logic [WAY_W-1:0]                     rf_way,
  input logic [TAG_W-1:0]                     rf_tag,
  input logic [WAYS-1:0]                      match_vec,
  input logic [SETS-1:0][WAYS-1:0]            valid_q,
  input logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q
);
  logic             inv_q, rf_q;
  logic [SET_W-1:0] inv_set_q, rf_set_q;
  logic [TAG_W-1:0] inv_tag_q, rf_tag_q;
  logic [WAY_W-1:0] rf_way_q;
  logic             inv_present;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_q     <= 1'b0;
      rf_q      <= 1'b0;
      inv_set_q <= '0;
      inv_tag_q <= '0;
      rf_set_q  <= '0;
      rf_tag_q  <= '0;
      rf_way_q  <= '0;
    end else begin
      inv_q     <= inv_en;
      rf_q      <= rf_commit;
      inv_set_q <= inv_set;
      inv_tag_q <= inv_tag;
      rf_set_q  <= rf_set;
      rf_tag_q  <= rf_tag;
      rf_way_q  <= rf_way;
    end
  end

  always_comb begin
    inv_present = 1'b0;
    for (int w = 0; w < WAYS; w++)
      if (valid_q[inv_set_q][w] && (tag_q[inv_set_q][w] == inv_tag_q))
        inv_present = 1'b1;
  end

  p_one_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |-> ($countones({lk_hit, lk_miss, lk_fault}) == 1));

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |-> !(lk_hit || lk_miss || lk_fault));

  p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (pa_off == lk_off));

  p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));

  p_no_dup_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  p_inv_gone_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_q |-> !inv_present);

  p_refill_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_q |-> (valid_q[rf_set_q][rf_way_q] && (tag_q[rf_set_q][rf_way_q] == rf_tag_q)));
endmodule

bind tlb_coherent tlb_coherent_chk #(
  .SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W), .TAG_W(TAG_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_req    (lk_req),
  .lk_hit    (lk_hit),
  .lk_miss   (lk_miss),
  .lk_fault  (lk_fault),
  .lk_off    (lk_vaddr[11:0]),
  .pa_off    (lk_paddr[11:0]),
  .flush     (tbl_base_wr),
  .inv_en    (entry_inv),
  .inv_set   (inv_set),
  .inv_tag   (inv_tag),
  .rf_commit (rf_commit),
  .rf_set    (rf_set),
  .rf_way    (rf_way),
  .rf_tag    (rf_tag),
  .match_vec (match_vec),
  .valid_q   (valid_q),
  .tag_q     (tag_q)
);

// File: tb/tb_tlb_coherent.sv
module tb_tlb_coherent;
  localparam int VA   = 32;
  localparam int PA   = 32;
  localparam int ENT  = 16;
  localparam int WY   = 4;
  localparam int NS   = ENT / WY;
  localparam int VPNW = VA - 12;
  localparam int PPNW = PA - 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            lk_req = 1'b0;
  logic [VA-1:0]   lk_vaddr = '0;
  logic [1:0]      lk_kind = '0;
  logic            lk_hit, lk_miss, lk_fault;
  logic [PA-1:0]   lk_paddr;
  logic            rf_req = 1'b0;
  logic [VPNW-1:0] rf_vpn = '0;
  logic [PPNW-1:0] rf_ppn = '0;
  logic            rf_rd = 1'b0, rf_wr = 1'b0, rf_ex = 1'b0, rf_dirty = 1'b0;
  logic            tbl_base_wr = 1'b0;
  logic            entry_inv = 1'b0;
  logic [VPNW-1:0] entry_inv_vpn = '0;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  tlb_coherent #(.VADDR_W(VA), .PADDR_W(PA), .ENTRIES(ENT), .WAYS(WY)) dut (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr), .lk_kind(lk_kind),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_paddr(lk_paddr),
    .rf_req(rf_req), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn), .rf_rd(rf_rd), .rf_wr(rf_wr),
    .rf_ex(rf_ex), .rf_dirty(rf_dirty), .tbl_base_wr(tbl_base_wr),
    .entry_inv(entry_inv), .entry_inv_vpn(entry_inv_vpn)
  );

  // reference model, perm bits {r,w,x,d}
  bit              m_v   [NS][WY];
  logic [VPNW-1:0] m_vpn [NS][WY];
  logic [PPNW-1:0] m_ppn [NS][WY];
  logic [3:0]      m_p   [NS][WY];
  int              m_age [NS][WY];

  function automatic int set_idx(logic [VPNW-1:0] v);
    return int'(v % NS);
  endfunction

  function automatic int find_way(logic [VPNW-1:0] v);
    int s = set_idx(v);
    for (int w = 0; w < WY; w++)
      if (m_v[s][w] && m_vpn[s][w] == v) return w;
    return -1;
  endfunction

  function automatic bit allowed(logic [3:0] p, logic [1:0] k);
    if (k == 2'b01) return p[2];
    if (k == 2'b10) return p[1];
    return p[3];
  endfunction

  task automatic touch(int s, int way);
    int a = m_age[s][way];
    for (int w = 0; w < WY; w++) begin
      if (w == way) m_age[s][w] = 0;
      else if (m_age[s][w] < a) m_age[s][w] = m_age[s][w] + 1;
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < WY; w++) begin
        m_v[s][w] = 0;
        m_age[s][w] = w;
      end
  endtask

  task automatic idle_inputs();
    lk_req = 0; lk_vaddr = '0; lk_kind = 0;
    rf_req = 0; rf_vpn = '0; rf_ppn = '0;
    {rf_rd, rf_wr, rf_ex, rf_dirty} = 4'b0;
    tbl_base_wr = 0; entry_inv = 0; entry_inv_vpn = '0;
  endtask

  // check outputs before the edge, then advance model with the edge
  task automatic do_cycle(string lbl);
    logic [VPNW-1:0] lv;
    int hw, ls, rs, pw;
    bit eh, em, ef, commit;
    logic [PA-1:0] ep;
    string tag;
    #1;
    lv = lk_vaddr[VA-1:12];
    ls = set_idx(lv);
    hw = find_way(lv);
    eh = 0; em = 0; ef = 0; ep = '0;
    if (lk_req) begin
      if (hw < 0) em = 1;
      else if (!allowed(m_p[ls][hw], lk_kind)) ef = 1;
      else if (lk_kind == 2'b01 && !m_p[ls][hw][0]) em = 1;
      else begin eh = 1; ep = {m_ppn[ls][hw], lk_vaddr[11:0]}; end
    end
    tag = lbl;
    if (tag == "") tag = !lk_req ? "R3" : eh ? "R2" : ef ? "R5" : (hw >= 0) ? "R6" : "R4";
    total++;
    if ({lk_hit, lk_miss, lk_fault} != {eh, em, ef} || lk_paddr != ep) begin
      bad++;
      $display("FAIL %s: hit/miss/fault=%b%b%b paddr=%h expected %b%b%b paddr=%h",
               tag, lk_hit, lk_miss, lk_fault, lk_paddr, eh, em, ef, ep);
    end
    @(posedge clk);
    rs = set_idx(rf_vpn);
    commit = rf_req && !tbl_base_wr && !(entry_inv && entry_inv_vpn == rf_vpn);
    pw = find_way(rf_vpn);
    if (pw < 0)
      for (int w = WY - 1; w >= 0; w--) if (!m_v[rs][w]) pw = w;
    if (pw < 0)
      for (int w = 0; w < WY; w++) if (m_age[rs][w] == WY - 1) pw = w;
    if (entry_inv) begin
      int iw = find_way(entry_inv_vpn);
      if (iw >= 0) m_v[set_idx(entry_inv_vpn)][iw] = 0;
    end
    if (commit) begin
      m_v[rs][pw] = 1; m_vpn[rs][pw] = rf_vpn; m_ppn[rs][pw] = rf_ppn;
      m_p[rs][pw] = {rf_rd, rf_wr, rf_ex, rf_dirty};
    end
    if (tbl_base_wr)
      for (int s = 0; s < NS; s++) for (int w = 0; w < WY; w++) m_v[s][w] = 0;
    if (commit) touch(rs, pw);
    else if (eh) touch(ls, hw);
    @(negedge clk);
  endtask

  task automatic lookup(int vpn, int off, logic [1:0] k, string lbl);
    idle_inputs();
    lk_req = 1; lk_vaddr = {VPNW'(vpn), 12'(off)}; lk_kind = k;
    do_cycle(lbl);
  endtask

  task automatic refill(int vpn, int ppn, logic [3:0] p, string lbl);
    idle_inputs();
    rf_req = 1; rf_vpn = VPNW'(vpn); rf_ppn = PPNW'(ppn);
    {rf_rd, rf_wr, rf_ex, rf_dirty} = p;
    do_cycle(lbl);
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: empty after reset
    lookup(5, 'h013, 2'b00, "R1");
    lookup(0, 'h000, 2'b10, "R1");

    // R4/R2: install then retry hits; paddr = ppn:offset
    refill(5, 'hABCDE, 4'b1101, "R4");
    lookup(5, 'h123, 2'b00, "R2");
    lookup(5, 'hFFF, 2'b01, "R2");
    // R5: exec not allowed -> fault; kind 11 acts as read
    lookup(5, 'h010, 2'b10, "R5");
    lookup(5, 'h010, 2'b11, "R5");

    // R6: write to clean page misses; dirty refill overwrites same way
    refill(9, 'h11111, 4'b1100, "R6");
    lookup(9, 'h004, 2'b01, "R6");
    lookup(9, 'h004, 2'b00, "R6");
    refill(9, 'h22222, 4'b1101, "R6");
    lookup(9, 'h008, 2'b01, "R6");

    // R9: set 1 fills in order without evicting
    refill(13, 'h33333, 4'b1011, "R9");
    refill(17, 'h44444, 4'b1000, "R9");
    lookup(5, 'h1, 2'b00, "R9");
    lookup(9, 'h2, 2'b00, "R9");
    lookup(13, 'h3, 2'b10, "R9");
    lookup(17, 'h4, 2'b00, "R9");

    // R10: touch 5, then a fifth page evicts the least recent (9)
    lookup(5, 'h5, 2'b00, "R10");
    refill(21, 'h55555, 4'b1111, "R10");
    lookup(9, 'h6, 2'b00, "R10");
    lookup(5, 'h7, 2'b00, "R10");
    lookup(21, 'h8, 2'b01, "R10");

    // R8: drop one page, neighbours stay; same-page refill is vetoed
    idle_inputs(); entry_inv = 1; entry_inv_vpn = VPNW'(13); do_cycle("R8");
    lookup(13, 'h9, 2'b00, "R8");
    lookup(17, 'h9, 2'b00, "R8");
    idle_inputs(); entry_inv = 1; entry_inv_vpn = VPNW'(13);
    rf_req = 1; rf_vpn = VPNW'(13); rf_ppn = 'h66666; {rf_rd, rf_wr, rf_ex, rf_dirty} = 4'b1000;
    do_cycle("R8");
    lookup(13, 'h9, 2'b00, "R8");

    // R7: flush with simultaneous refill keeps nothing
    idle_inputs(); tbl_base_wr = 1;
    rf_req = 1; rf_vpn = VPNW'(2); rf_ppn = 'h77777; {rf_rd, rf_wr, rf_ex, rf_dirty} = 4'b1000;
    do_cycle("R7");
    lookup(5, 'h1, 2'b00, "R7");
    lookup(2, 'h1, 2'b00, "R7");
    lookup(21, 'h1, 2'b00, "R7");
    idle_inputs(); do_cycle("R3");

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      idle_inputs();
      if ($urandom_range(0, 9) < 8) begin
        lk_req = 1;
        lk_vaddr = {VPNW'($urandom_range(0, 19)), 12'($urandom)};
        lk_kind = 2'($urandom_range(0, 3));
      end
      if ($urandom_range(0, 9) < 3) begin
        rf_req = 1; rf_vpn = VPNW'($urandom_range(0, 19)); rf_ppn = PPNW'($urandom);
        {rf_rd, rf_wr, rf_ex, rf_dirty} = 4'($urandom);
      end
      if ($urandom_range(0, 9) == 0) begin
        entry_inv = 1; entry_inv_vpn = VPNW'($urandom_range(0, 19));
      end
      if ($urandom_range(0, 99) < 2) tbl_base_wr = 1;
      do_cycle("");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule